// File: doc/BRIEF.md
# Multi-Wide Reorder Buffer

This block is the in-order backbone of an out-of-order core. Each clock, the front end may claim up to three consecutive slots in a 40-slot circular buffer. The claimed slots are handed back as tags, in program order. Execution units later report each result against its tag, in whatever order they finish. A slot keeps its result, together with an exception marker, until that slot reaches the oldest position. The slot therefore serves as the physical home of the value until then.

From the oldest end, up to three finished slots per clock are committed. Each commit is presented on a retire port that writes the architectural register file held outside the block. Commit halts at the first slot that has not finished, or that carries an exception. A faulting slot at the commit point is not written back. Instead it empties the whole buffer in one cycle. An external flush input does the same.

Top module: `reorder_buffer`

## Requirements
- R1: The buffer holds at most 40 slots, with tags 0 to 39. Once 40 slots are in flight, any further allocation request is refused.
- R2: An accepted request of n slots (n from 1 to 3, given on `alloc_cnt_i`) claims the n tags that follow the last claimed tag, modulo 40. Lane k of `alloc_tag_o` (bits 6k+5:6k) carries the k-th tag, and lane k of `alloc_dst_i` (bits 5k+4:5k) gives its destination register index.
- R3: `alloc_ok_o` is high only when the number of free slots, counted before this cycle's commits, is at least the number requested. A refused request claims no slot at all.
- R4: A completion writes its result and exception flag into the slot named by `cmp_tag_i`. Completions may arrive in any order. A completion to a tag that is not in flight has no effect.
- R5: Commits happen in program order, at most three per clock, on lanes 0 to 2. Lane k is enabled only if lanes below it are enabled. A slot completed at one clock edge can commit in the following cycle at the earliest.
- R6: Commit stops at the oldest slot that has not completed. Younger completed slots wait behind it, even when they fall within the same three-slot window.
- R7: When the first slot that does not commit in a cycle has completed with its exception flag set, `exc_flush_o` is high in that cycle. That slot and every younger slot are discarded and are not written. Older slots in the same window still commit.
- R8: `flush_i`, or an exception flush, empties the buffer at the next edge and returns both ends to tag 0. Allocation and completion requests in that cycle are ignored, and the next tag issued is 0.
- R9: The index and data on a commit lane are the destination given at allocation and the result given at completion for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard all slots |
| alloc_cnt_i | input | 2 | Number of slots requested this cycle (0 to 3) |
| alloc_dst_i | input | 15 | Destination register index per lane |
| alloc_ok_o | output | 1 | Request accepted |
| alloc_tag_o | output | 18 | Tag per allocation lane |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_tag_i | input | 6 | Tag of the completing slot |
| cmp_data_i | input | 32 | Result value |
| cmp_exc_i | input | 1 | Result raised an exception |
| ret_we_o | output | 3 | Commit enable per lane |
| ret_idx_o | output | 15 | Architectural register index per lane |
| ret_data_o | output | 96 | Committed value per lane |
| exc_flush_o | output | 1 | Faulting slot reached the commit point |

## Verification
Allocation acceptance and tags depend only on the current request and the stored pointers, so they are due in the same cycle as the request. A completion or allocation becomes visible on the commit lanes one edge later. The effect of a flush shows one edge later, on the next tag issued. The bench drives each cycle's inputs just after the falling edge. It reads every output one nanosecond later, before the next rising edge. At that point it compares the outputs with a slot-queue model that updates only after that rising edge. Each comparison is thus made against the state that the registers hold in that cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_DEPTH = 40;
    localparam int ROB_WAYS  = 3;
    localparam int XLEN      = 32;
    localparam int AREG_W    = 5;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        logic [AREG_W-1:0] dst;
        logic [XLEN-1:0]   data;
    } rob_entry_t;

    function automatic int wrap_add(input int base, input int off, input int depth);
        int s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    parameter int WAYS  = ROB_WAYS,
    parameter int TAG_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int NW    = $clog2(WAYS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic [NW-1:0]              alloc_n,
    input  logic [NW-1:0]              ret_n,
    output logic                       alloc_ok,
    output logic                       alloc_go,
    output logic [WAYS-1:0][TAG_W-1:0] head_tags,
    output logic [WAYS-1:0][TAG_W-1:0] tail_tags,
    output logic [CNT_W-1:0]           occ
);

    logic [TAG_W-1:0] head_q;
    logic [TAG_W-1:0] tail_q;
    logic [CNT_W-1:0] occ_q;
    logic [CNT_W-1:0] free_cnt;

    assign free_cnt = CNT_W'(DEPTH) - occ_q;
    assign alloc_ok = (CNT_W'(alloc_n) <= free_cnt) && !clear;
    assign alloc_go = alloc_ok && (alloc_n != '0);
    assign occ      = occ_q;

    for (genvar k = 0; k < WAYS; k++) begin : g_tags
        assign head_tags[k] = TAG_W'(wrap_add(int'(head_q), k, DEPTH));
        assign tail_tags[k] = TAG_W'(wrap_add(int'(tail_q), k, DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            head_q <= TAG_W'(wrap_add(int'(head_q), int'(ret_n), DEPTH));
            if (alloc_go)
                tail_q <= TAG_W'(wrap_add(int'(tail_q), int'(alloc_n), DEPTH));
            occ_q <= occ_q + (alloc_go ? CNT_W'(alloc_n) : '0) - CNT_W'(ret_n);
        end
    end

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    parameter int WAYS  = ROB_WAYS,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear,
    input  logic [WAYS-1:0]             alloc_we,
    input  logic [WAYS-1:0][TAG_W-1:0]  alloc_tag,
    input  logic [WAYS-1:0][AREG_W-1:0] alloc_dst,
    input  logic                        cmp_we,
    input  logic [TAG_W-1:0]            cmp_tag,
    input  logic [XLEN-1:0]             cmp_data,
    input  logic                        cmp_exc,
    input  logic [WAYS-1:0]             ret_clr,
    input  logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output rob_entry_t                  rd_ent [WAYS]
);

    rob_entry_t slots [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rob_entry_t        ent_q;
        logic              a_hit;
        logic              r_hit;
        logic [AREG_W-1:0] a_dst;

        always_comb begin
            a_hit = 1'b0;
            r_hit = 1'b0;
            a_dst = '0;
            for (int k = 0; k < WAYS; k++) begin
                if (alloc_we[k] && alloc_tag[k] == TAG_W'(i)) begin
                    a_hit = 1'b1;
                    a_dst = alloc_dst[k];
                end
                if (ret_clr[k] && rd_tag[k] == TAG_W'(i))
                    r_hit = 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                ent_q <= '0;
            end else if (a_hit) begin
                ent_q <= '{valid: 1'b1, done: 1'b0, exc: 1'b0, dst: a_dst, data: '0};
            end else begin
                if (cmp_we && cmp_tag == TAG_W'(i) && ent_q.valid) begin
                    ent_q.done <= 1'b1;
                    ent_q.exc  <= cmp_exc;
                    ent_q.data <= cmp_data;
                end
                if (r_hit)
                    ent_q.valid <= 1'b0;
            end
        end

        assign slots[i] = ent_q;
    end

    for (genvar k = 0; k < WAYS; k++) begin : g_read
        assign rd_ent[k] = slots[rd_tag[k]];
    end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int WAYS = ROB_WAYS,
    parameter int NW   = $clog2(WAYS + 1)
) (
    input  rob_entry_t      win [WAYS],
    output logic [WAYS-1:0] ret_go,
    output logic [NW-1:0]   ret_n,
    output logic            exc_hit
);

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        ret_go  = '0;
        ret_n   = '0;
        exc_hit = 1'b0;
        for (int k = 0; k < WAYS; k++) begin
            if (!blocked) begin
                if (win[k].valid && win[k].done && !win[k].exc) begin
                    ret_go[k] = 1'b1;
                    ret_n     = ret_n + NW'(1);
                end else begin
                    blocked = 1'b1;
                    if (win[k].valid && win[k].done && win[k].exc)
                        exc_hit = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH = ROB_DEPTH,
    parameter int WAYS  = ROB_WAYS,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(WAYS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush_i,
    input  logic [NW-1:0]            alloc_cnt_i,
    input  logic [WAYS*AREG_W-1:0]   alloc_dst_i,
    output logic                     alloc_ok_o,
    output logic [WAYS*TAG_W-1:0]    alloc_tag_o,
    input  logic                     cmp_valid_i,
    input  logic [TAG_W-1:0]         cmp_tag_i,
    input  logic [XLEN-1:0]          cmp_data_i,
    input  logic                     cmp_exc_i,
    output logic [WAYS-1:0]          ret_we_o,
    output logic [WAYS*AREG_W-1:0]   ret_idx_o,
    output logic [WAYS*XLEN-1:0]     ret_data_o,
    output logic                     exc_flush_o
);

    logic                        clear;
    logic                        alloc_go;
    logic [WAYS-1:0]             alloc_we;
    logic [WAYS-1:0][TAG_W-1:0]  head_tags;
    logic [WAYS-1:0][TAG_W-1:0]  tail_tags;
    logic [WAYS-1:0][AREG_W-1:0] dst_lanes;
    logic [NW-1:0]               ret_n;
    logic [WAYS-1:0]             ret_go;
    logic                        exc_hit;
    logic [CNT_W-1:0]            occ_cnt;
    rob_entry_t                  win [WAYS];

    assign clear       = flush_i || exc_hit;
    assign exc_flush_o = exc_hit;

    for (genvar k = 0; k < WAYS; k++) begin : g_lane
        assign dst_lanes[k]                      = alloc_dst_i[k*AREG_W +: AREG_W];
        assign alloc_we[k]                       = alloc_go && (NW'(k) < alloc_cnt_i);
        assign alloc_tag_o[k*TAG_W +: TAG_W]     = tail_tags[k];
        assign ret_we_o[k]                       = ret_go[k];
        assign ret_idx_o[k*AREG_W +: AREG_W]     = win[k].dst;
        assign ret_data_o[k*XLEN +: XLEN]        = win[k].data;
    end

    rob_ptr_ctl #(
        .DEPTH(DEPTH), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W), .NW(NW)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .alloc_n  (alloc_cnt_i),
        .ret_n    (ret_n),
        .alloc_ok (alloc_ok_o),
        .alloc_go (alloc_go),
        .head_tags(head_tags),
        .tail_tags(tail_tags),
        .occ      (occ_cnt)
    );

    rob_entry_array #(
        .DEPTH(DEPTH), .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_arr (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .alloc_we (alloc_we),
        .alloc_tag(tail_tags),
        .alloc_dst(dst_lanes),
        .cmp_we   (cmp_valid_i),
        .cmp_tag  (cmp_tag_i),
        .cmp_data (cmp_data_i),
        .cmp_exc  (cmp_exc_i),
        .ret_clr  (ret_go),
        .rd_tag   (head_tags),
        .rd_ent   (win)
    );

    rob_retire_sel #(
        .WAYS(WAYS), .NW(NW)
    ) u_sel (
        .win    (win),
        .ret_go (ret_go),
        .ret_n  (ret_n),
        .exc_hit(exc_hit)
    );

endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 40,
    parameter int WAYS  = 3,
    parameter int CNT_W = 6,
    parameter int NW    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic [NW-1:0]    alloc_cnt_i,
    input logic             alloc_ok_o,
    input logic [WAYS-1:0]  ret_we_o,
    input logic             exc_flush_o,
    input logic [CNT_W-1:0] occ
);

    int acc_n;
    int ret_cnt;

    always_comb begin
        acc_n   = alloc_ok_o ? int'(alloc_cnt_i) : 0;
        ret_cnt = $countones(ret_we_o);
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(occ) <= DEPTH); // R1

    AST_OCC_TRACK: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && !exc_flush_o) |=> int'(occ) == int'($past(occ)) + $past(acc_n) - $past(ret_cnt)); // R2

    AST_STALL_SHORT: assert property (@(posedge clk) disable iff (rst)
        (int'(alloc_cnt_i) > DEPTH - int'(occ)) |-> !alloc_ok_o); // R3

    AST_RET_PREFIX: assert property (@(posedge clk) disable iff (rst)
        (ret_we_o & (ret_we_o + 1'b1)) == '0); // R5

    AST_EXC_EMPTY: assert property (@(posedge clk) disable iff (rst)
        exc_flush_o |=> occ == '0); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> occ == '0); // R8

endmodule

bind reorder_buffer rob_checker #(
    .DEPTH(DEPTH), .WAYS(WAYS), .CNT_W(CNT_W), .NW(NW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .alloc_cnt_i(alloc_cnt_i),
    .alloc_ok_o (alloc_ok_o),
    .ret_we_o   (ret_we_o),
    .exc_flush_o(exc_flush_o),
    .occ        (occ_cnt)
);

// File: tb/reorder_buffer_tb_top.sv
`timescale 1ns/1ps
module reorder_buffer_tb_top;
    import rob_pkg::*;

    localparam int D  = ROB_DEPTH;
    localparam int W  = ROB_WAYS;
    localparam int TW = $clog2(D);
    localparam int NW = $clog2(W + 1);

    // row: [1:0] slots requested, [3:2] first lane completed, [5:4] second, [7:6] third
    localparam logic [7:0] PAT [8] = '{
        8'b10_01_00_11, 8'b00_01_10_11, 8'b01_00_10_11, 8'b00_10_01_11,
        8'b10_00_01_10, 8'b10_01_00_10, 8'b00_00_00_01, 8'b10_00_01_11
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 flush_i = 1'b0;
    logic [NW-1:0]        alloc_cnt_i = '0;
    logic [W*AREG_W-1:0]  alloc_dst_i = '0;
    logic                 alloc_ok_o;
    logic [W*TW-1:0]      alloc_tag_o;
    logic                 cmp_valid_i = 1'b0;
    logic [TW-1:0]        cmp_tag_i = '0;
    logic [XLEN-1:0]      cmp_data_i = '0;
    logic                 cmp_exc_i = 1'b0;
    logic [W-1:0]         ret_we_o;
    logic [W*AREG_W-1:0]  ret_idx_o;
    logic [W*XLEN-1:0]    ret_data_o;
    logic                 exc_flush_o;

    always #2.5 clk = ~clk;

    reorder_buffer dut_i (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .alloc_cnt_i(alloc_cnt_i), .alloc_dst_i(alloc_dst_i),
        .alloc_ok_o(alloc_ok_o), .alloc_tag_o(alloc_tag_o),
        .cmp_valid_i(cmp_valid_i), .cmp_tag_i(cmp_tag_i),
        .cmp_data_i(cmp_data_i), .cmp_exc_i(cmp_exc_i),
        .ret_we_o(ret_we_o), .ret_idx_o(ret_idx_o),
        .ret_data_o(ret_data_o), .exc_flush_o(exc_flush_o)
    );

    int total = 0;
    int bad   = 0;

    // slot-queue model
    int               m_q[$];
    int               m_tail = 0;
    bit               m_done [D];
    bit               m_exc  [D];
    logic [AREG_W-1:0] m_dst [D];
    logic [XLEN-1:0]  m_data [D];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_flight(input int t);
        foreach (m_q[i]) if (m_q[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    // check this cycle's outputs against the model, then advance one clock
    task automatic tick();
        int  exp_n;
        bit  exp_exc;
        bit  blk;
        bit  exp_ok;
        int  n;
        int  t;
        #1;
        exp_n = 0; exp_exc = 1'b0; blk = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (!blk) begin
                if (k < m_q.size() && m_done[m_q[k]] && !m_exc[m_q[k]]) exp_n++;
                else begin
                    blk = 1'b1;
                    if (k < m_q.size() && m_done[m_q[k]] && m_exc[m_q[k]]) exp_exc = 1'b1;
                end
            end
        end
        for (int k = 0; k < W; k++) begin
            chk(ret_we_o[k] == (k < exp_n), "R5/R6", "commit lane enable",
                64'(ret_we_o[k]), 64'(k < exp_n));
            if (ret_we_o[k] && k < exp_n) begin
                chk(ret_idx_o[k*AREG_W +: AREG_W] == m_dst[m_q[k]], "R9", "commit index",
                    64'(ret_idx_o[k*AREG_W +: AREG_W]), 64'(m_dst[m_q[k]]));
                chk(ret_data_o[k*XLEN +: XLEN] == m_data[m_q[k]], "R9", "commit data",
                    64'(ret_data_o[k*XLEN +: XLEN]), 64'(m_data[m_q[k]]));
            end
        end
        chk(exc_flush_o == exp_exc, "R7", "exception flush", 64'(exc_flush_o), 64'(exp_exc));
        n = int'(alloc_cnt_i);
        exp_ok = (n <= D - m_q.size()) && !flush_i && !exp_exc;
        chk(alloc_ok_o == exp_ok, "R1/R3", "alloc accept", 64'(alloc_ok_o), 64'(exp_ok));
        if (exp_ok) begin
            for (int k = 0; k < n; k++)
                chk(int'(alloc_tag_o[k*TW +: TW]) == (m_tail + k) % D, "R2/R8", "alloc tag",
                    64'(alloc_tag_o[k*TW +: TW]), 64'((m_tail + k) % D));
        end
        @(posedge clk);
        for (int k = 0; k < exp_n; k++) void'(m_q.pop_front());
        if (flush_i || exp_exc) begin
            m_q.delete();
            m_tail = 0;
        end else begin
            if (cmp_valid_i && in_flight(int'(cmp_tag_i))) begin
                m_done[cmp_tag_i] = 1'b1;
                m_exc[cmp_tag_i]  = cmp_exc_i;
                m_data[cmp_tag_i] = cmp_data_i;
            end
            if (exp_ok) begin
                for (int k = 0; k < n; k++) begin
                    t = (m_tail + k) % D;
                    m_q.push_back(t);
                    m_done[t] = 1'b0;
                    m_exc[t]  = 1'b0;
                    m_dst[t]  = alloc_dst_i[k*AREG_W +: AREG_W];
                end
                m_tail = (m_tail + n) % D;
            end
        end
        @(negedge clk);
        alloc_cnt_i = '0;
        cmp_valid_i = 1'b0;
        cmp_exc_i   = 1'b0;
        flush_i     = 1'b0;
    endtask

    task automatic req_alloc(input int n, input int seed);
        alloc_cnt_i = NW'(n);
        for (int k = 0; k < W; k++)
            alloc_dst_i[k*AREG_W +: AREG_W] = AREG_W'(seed + k);
    endtask

    task automatic req_cmp(input int t, input logic [XLEN-1:0] v, input bit e);
        cmp_valid_i = 1'b1;
        cmp_tag_i   = TW'(t);
        cmp_data_i  = v;
        cmp_exc_i   = e;
    endtask

    initial begin
        #750000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        int lane;
        int head;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(ret_we_o == '0, "R5", "reset commit lanes", 64'(ret_we_o), 64'(0));
        chk(exc_flush_o == 1'b0, "R7", "reset exception flush", 64'(exc_flush_o), 64'(0));
        chk(alloc_tag_o[TW-1:0] == '0, "R8", "reset first tag", 64'(alloc_tag_o[TW-1:0]), 64'(0));
        @(negedge clk);

        // vector table: allocate, complete in the listed lane order, drain
        for (int r = 0; r < 8; r++) begin
            base = m_tail;
            req_alloc(int'(PAT[r][1:0]), r * 3);
            tick();
            for (int j = 0; j < int'(PAT[r][1:0]); j++) begin
                lane = int'(PAT[r][2 + 2*j +: 2]);
                req_cmp((base + lane) % D, 32'hA000_0000 + 32'(r * 16 + lane), 1'b0);
                tick();
            end
            repeat (3) tick();
            chk(m_q.size() == 0, "R4", "table row drained", 64'(m_q.size()), 64'(0));
        end

        // fill to capacity; requests beyond 40 slots are refused (R1, R3)
        for (int i = 0; i < 13; i++) begin
            req_alloc(3, i);
            tick();
        end
        req_alloc(3, 7); tick();
        req_alloc(1, 9); tick();
        req_alloc(1, 4); tick();
        chk(m_q.size() == D, "R1", "slots in flight at capacity", 64'(m_q.size()), 64'(D));

        // complete all but the oldest: nothing may commit (R6)
        head = m_q[0];
        for (int i = 1; i < D; i++) begin
            req_cmp(m_q[i], 32'h5500_0000 + 32'(i), 1'b0);
            tick();
        end
        req_cmp(head, 32'h5500_0000, 1'b0);
        tick();
        repeat (14) tick();
        chk(m_q.size() == 0, "R5", "full buffer drained three per cycle", 64'(m_q.size()), 64'(0));

        // exception in the middle lane: older lane commits, rest discarded (R7)
        base = m_tail;
        req_alloc(3, 20); tick();
        req_cmp((base + 1) % D, 32'hDEAD_0001, 1'b1); tick();
        req_cmp((base + 2) % D, 32'hBEEF_0002, 1'b0); tick();
        req_cmp(base, 32'hC0DE_0000, 1'b0); tick();
        tick();
        req_alloc(1, 25); tick();
        chk(m_q.size() == 1 && m_q[0] == 0, "R8", "tag after exception flush",
            64'(m_q[0]), 64'(0));

        // external flush ignores a same-cycle request and completion (R8)
        req_alloc(2, 26); tick();
        req_cmp(1, 32'h1111_1111, 1'b0);
        req_alloc(2, 28);
        flush_i = 1'b1;
        tick();
        req_alloc(1, 30); tick();
        // stale completion to a tag not in flight is ignored (R4)
        req_cmp(5, 32'h2222_2222, 1'b0); tick();
        repeat (3) tick();
        req_cmp(0, 32'h3333_3333, 1'b0); tick();
        tick();
        chk(m_q.size() == 0, "R4", "only live completion drained", 64'(m_q.size()), 64'(0));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule